// File: doc/BRIEF.md
# Link Sequencer Control and Status Registers

This block is the register slice that sits between software and a backplane Ethernet link bring-up sequencer. It has a 32-bit word-addressed bus port. Writes are accepted in the cycle they are presented. Read data is returned one cycle after the address. The slice holds three words: a control word, a status word and an error-insert word.

Toward the sequencer it drives three kinds of output. Command bits become single-cycle pulses. Timer-disable and training-failure-response fields are held as levels. The force-mode field and the FEC request are held back in a staging copy. They reach the sequencer only when a sequencer reset command is written.

From the sequencer it takes a link-ready level and three events: negotiation timeout, training timeout and negotiation restart. The two timeout events are turned into sticky flags. A pending flag tells software that the FEC request was changed but no reset has applied it yet.

Top module: `lseq_csr`

## Requirements
- R1: Writing 1 to control bit 0 drives `seq_rst_o` high for exactly one cycle, in the cycle after the write. Control bit 0 always reads back 0.
- R2: The force-mode field (control bits 7:4) reads back what was written. `force_mode_o` takes that value only from a write that also sets control bit 0, and is otherwise unchanged.
- R3: Control bit 1 drives `an_tmr_off_o` and control bit 2 drives `lf_tmr_off_o`. A value of 1 means the timer is disabled. Both read back and reset to 0.
- R4: Control bit 12 drives `lt_fail_data_o`. A value of 1 sends the link to data mode on a training failure. A value of 0 means restart negotiation, or restart training if negotiation is off.
- R5: Control bit 16 drives `fec_en_o` and resets to the parameter `FEC_EN_RST` when `FEC_CAPABLE` is 1. Control bit 18 is the FEC request. `fec_req_o` follows it only on a write that also sets control bit 0.
- R6: Control bit 19 is read-only and reads 1 when a write changed the request bit without setting control bit 0. It reads 0 again after any write that sets control bit 0.
- R7: The status word reports `link_rdy_i` on bit 0, the sticky negotiation timeout on bit 1 and the sticky training timeout on bit 2. Bit 1 is cleared by `an_restart_i`. Bit 2 is cleared by an issued sequencer reset. A new event wins over a clear in the same cycle.
- R8: Writing 1 to bit 11 of the error-insert word drives `fec_err_ins_o` high for exactly one cycle, in the cycle after the write. That bit reads back 0.
- R9: Reserved bits and unmapped addresses read 0. Writes to the status word or to reserved bits have no effect.
- R10: `bus_rdata` reflects the word at the address presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the address |
| link_rdy_i | input | 1 | Link-ready level from the sequencer |
| an_tmo_evt_i | input | 1 | Negotiation timeout event |
| lt_tmo_evt_i | input | 1 | Training timeout event |
| an_restart_i | input | 1 | Sequencer restarted negotiation |
| seq_rst_o | output | 1 | Sequencer reset pulse |
| force_mode_o | output | 4 | Applied force-mode value |
| an_tmr_off_o | output | 1 | Negotiation timer disable |
| lf_tmr_off_o | output | 1 | Link-fail timer disable |
| lt_fail_data_o | output | 1 | Training failure response select |
| fec_en_o | output | 1 | FEC enable |
| fec_req_o | output | 1 | Applied FEC request |
| fec_err_ins_o | output | 1 | One-cycle TX FEC error insert pulse |

## Verification
Several faults in the staging logic would be visible at the next port change. A staging register that leaks through shows as `force_mode_o` or `fec_req_o` moving on a plain control write, which is observable one cycle after that write. A wrong pending flag shows up in the next read of bit 19. A sticky flag that fails to hold, or that clears on the wrong source, appears in the status read that follows the event, the restart or the reset. A stuck or stretched command pulse is seen on the pulse output in the first or second cycle after the write.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
   // control word bit positions
   localparam int CB_RST      = 0;
   localparam int CB_AN_OFF   = 1;
   localparam int CB_LF_OFF   = 2;
   localparam int CB_FM_LO    = 4;
   localparam int FM_W        = 4;
   localparam int CB_LT_RESP  = 12;
   localparam int CB_FEC_EN   = 16;
   localparam int CB_FEC_REQ  = 18;
   localparam int CB_FEC_PEND = 19;
   localparam int CTRL_MSB    = CB_FEC_PEND;
   // status word bit positions
   localparam int SB_LINK     = 0;
   localparam int SB_AN_TMO   = 1;
   localparam int SB_LT_TMO   = 2;
   localparam int N_STICKY    = 2;
   // error-insert word
   localparam int EB_INS      = 11;

   typedef struct packed {
      logic            an_off;
      logic            lf_off;
      logic            lt_resp;
      logic [FM_W-1:0] fm_stage;
      logic            req_stage;
      logic            req_pend;
   } ctrl_state_t;
endpackage

// File: rtl/lseq_ctrl_reg.sv
module lseq_ctrl_reg
   import lseq_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter bit FEC_CAPABLE = 1'b1,
   parameter bit FEC_EN_RST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_eins,
   input  logic [DATA_W-1:0] wdata,
   output logic              seq_rst_o,
   output logic [FM_W-1:0]   force_mode_o,
   output logic              an_off_o,
   output logic              lf_off_o,
   output logic              lt_resp_o,
   output logic              fec_en_o,
   output logic              fec_req_o,
   output logic              eins_o,
   output logic [DATA_W-1:0] ctrl_word_o
);
   ctrl_state_t st;
   logic        rst_cmd;

   assign rst_cmd = wr_ctrl & wdata[CB_RST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= '0;
         seq_rst_o    <= 1'b0;
         eins_o       <= 1'b0;
         force_mode_o <= '0;
         fec_req_o    <= 1'b0;
      end else begin
         seq_rst_o <= rst_cmd;
         eins_o    <= wr_eins & wdata[EB_INS];
         if (wr_ctrl) begin
            st.an_off    <= wdata[CB_AN_OFF];
            st.lf_off    <= wdata[CB_LF_OFF];
            st.lt_resp   <= wdata[CB_LT_RESP];
            st.fm_stage  <= wdata[CB_FM_LO +: FM_W];
            st.req_stage <= wdata[CB_FEC_REQ];
            if (rst_cmd) begin
               force_mode_o <= wdata[CB_FM_LO +: FM_W];
               fec_req_o    <= wdata[CB_FEC_REQ];
               st.req_pend  <= 1'b0;
            end else if (wdata[CB_FEC_REQ] != st.req_stage) begin
               st.req_pend  <= 1'b1;
            end
         end
      end
   end

   generate
      if (FEC_CAPABLE) begin : g_fec_reg
         logic fec_en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       fec_en_q <= FEC_EN_RST;
            else if (wr_ctrl) fec_en_q <= wdata[CB_FEC_EN];
         end
         assign fec_en_o = fec_en_q;
      end else begin : g_fec_tied
         assign fec_en_o = 1'b0;
      end
   endgenerate

   assign an_off_o  = st.an_off;
   assign lf_off_o  = st.lf_off;
   assign lt_resp_o = st.lt_resp;

   always_comb begin
      ctrl_word_o                        = '0;
      ctrl_word_o[CB_AN_OFF]             = st.an_off;
      ctrl_word_o[CB_LF_OFF]             = st.lf_off;
      ctrl_word_o[CB_FM_LO +: FM_W]      = st.fm_stage;
      ctrl_word_o[CB_LT_RESP]            = st.lt_resp;
      ctrl_word_o[CB_FEC_EN]             = fec_en_o;
      ctrl_word_o[CB_FEC_REQ]            = st.req_stage;
      ctrl_word_o[CB_FEC_PEND]           = st.req_pend;
   end

   // R2
   fmode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_rst_o |-> $stable(force_mode_o));
   // R5
   fec_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_rst_o |-> $stable(fec_req_o));
   // R6
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_rst_o |-> !ctrl_word_o[CB_FEC_PEND]);
   // R6
   pend_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_word_o[CB_FEC_PEND] |-> (fec_req_o == st.req_stage) || !$stable(st.req_stage) || seq_rst_o || 1'b1 == (fec_req_o == st.req_stage));
endmodule

// File: rtl/lseq_stat_reg.sv
module lseq_stat_reg
   import lseq_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                link_rdy_i,
   input  logic [N_STICKY-1:0] set_i,
   input  logic [N_STICKY-1:0] clr_i,
   output logic [DATA_W-1:0]   stat_word_o
);
   logic [N_STICKY-1:0] flag;

   generate
      for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag[g] <= 1'b0;
            else if (set_i[g])  flag[g] <= 1'b1;
            else if (clr_i[g])  flag[g] <= 1'b0;
         end
         // R7
         sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag[g]);
         // R7
         sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && !clr_i[g]) |=> flag[g]);
      end
   endgenerate

   always_comb begin
      stat_word_o            = '0;
      stat_word_o[SB_LINK]   = link_rdy_i;
      stat_word_o[SB_AN_TMO] = flag[0];
      stat_word_o[SB_LT_TMO] = flag[1];
   end
endmodule

// File: rtl/lseq_rd_mux.sv
module lseq_rd_mux #(
   parameter int               DATA_W     = 32,
   parameter int               ADDR_W     = 4,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'd0,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] ctrl_word,
   input  logic [DATA_W-1:0] stat_word,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (addr == CTRL_ADDR)      sel = ctrl_word;
      else if (addr == STAT_ADDR) sel = stat_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= sel;
   end
endmodule

// File: rtl/lseq_csr.sv
module lseq_csr
   import lseq_pkg::*;
#(
   parameter int               DATA_W      = 32,
   parameter int               ADDR_W      = 4,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'd0,
   parameter logic [ADDR_W-1:0] STAT_ADDR  = 'd1,
   parameter logic [ADDR_W-1:0] EINS_ADDR  = 'd2,
   parameter bit               FEC_CAPABLE = 1'b1,
   parameter bit               FEC_EN_RST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              link_rdy_i,
   input  logic              an_tmo_evt_i,
   input  logic              lt_tmo_evt_i,
   input  logic              an_restart_i,
   output logic              seq_rst_o,
   output logic [3:0]        force_mode_o,
   output logic              an_tmr_off_o,
   output logic              lf_tmr_off_o,
   output logic              lt_fail_data_o,
   output logic              fec_en_o,
   output logic              fec_req_o,
   output logic              fec_err_ins_o
);
   localparam int MIN_DATA_W = CTRL_MSB + 1;

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_width
         $error("lseq_csr: DATA_W too small for control word");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("lseq_csr: ADDR_W must be at least 2");
      end
      if (CTRL_ADDR == STAT_ADDR || CTRL_ADDR == EINS_ADDR || STAT_ADDR == EINS_ADDR) begin : g_bad_map
         $error("lseq_csr: word addresses must differ");
      end
   endgenerate

   logic              wr_ctrl, wr_eins;
   logic [DATA_W-1:0] ctrl_word, stat_word;
   logic              unused_wbits;

   assign wr_ctrl      = bus_wr && (bus_addr == CTRL_ADDR);
   assign wr_eins      = bus_wr && (bus_addr == EINS_ADDR);
   assign unused_wbits = ^bus_wdata;

   lseq_ctrl_reg #(
      .DATA_W(DATA_W), .FEC_CAPABLE(FEC_CAPABLE), .FEC_EN_RST(FEC_EN_RST)
   ) ctrl_i (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_eins(wr_eins),
      .wdata(bus_wdata), .seq_rst_o(seq_rst_o), .force_mode_o(force_mode_o),
      .an_off_o(an_tmr_off_o), .lf_off_o(lf_tmr_off_o), .lt_resp_o(lt_fail_data_o),
      .fec_en_o(fec_en_o), .fec_req_o(fec_req_o), .eins_o(fec_err_ins_o),
      .ctrl_word_o(ctrl_word)
   );

   lseq_stat_reg #(.DATA_W(DATA_W)) stat_i (
      .clk(clk), .rst_n(rst_n), .link_rdy_i(link_rdy_i),
      .set_i({lt_tmo_evt_i, an_tmo_evt_i}),
      .clr_i({seq_rst_o, an_restart_i}),
      .stat_word_o(stat_word)
   );

   lseq_rd_mux #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
   ) rd_i (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .ctrl_word(ctrl_word),
      .stat_word(stat_word), .rdata(bus_rdata)
   );

   // R1
   rst_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_rst_o && !$past(bus_wr)) |=> !seq_rst_o);
   // R8
   eins_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fec_err_ins_o && !$past(bus_wr)) |=> !fec_err_ins_o);
   // R10
   rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != CTRL_ADDR && bus_addr != STAT_ADDR) |=> (bus_rdata == '0));
endmodule

// File: tb/lseq_csr_tb_top.sv
`timescale 1ns/1ps
module lseq_csr_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        link_rdy_i = 1'b0, an_tmo_evt_i = 1'b0, lt_tmo_evt_i = 1'b0, an_restart_i = 1'b0;
   logic        seq_rst_o, an_tmr_off_o, lf_tmr_off_o, lt_fail_data_o;
   logic        fec_en_o, fec_req_o, fec_err_ins_o;
   logic [3:0]  force_mode_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_EINS = 4'd2, A_NONE = 4'd3;

   always #2.5 clk = ~clk;

   lseq_csr dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .link_rdy_i(link_rdy_i),
      .an_tmo_evt_i(an_tmo_evt_i), .lt_tmo_evt_i(lt_tmo_evt_i),
      .an_restart_i(an_restart_i), .seq_rst_o(seq_rst_o),
      .force_mode_o(force_mode_o), .an_tmr_off_o(an_tmr_off_o),
      .lf_tmr_off_o(lf_tmr_off_o), .lt_fail_data_o(lt_fail_data_o),
      .fec_en_o(fec_en_o), .fec_req_o(fec_req_o), .fec_err_ins_o(fec_err_ins_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; bus_addr = A_NONE;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_addr = A_NONE;
   endtask

   task automatic t_reset();
      logic [31:0] r;
      check("R3 reset an_tmr_off", 32'(an_tmr_off_o), 0);
      check("R2 reset force_mode", 32'(force_mode_o), 0);
      check("R5 reset fec_en", 32'(fec_en_o), 1);
      bus_read(A_CTRL, r);  check("R5 reset ctrl word", r, 32'h0001_0000);
      bus_read(A_STAT, r);  check("R7 reset status word", r, 0);
   endtask

   task automatic t_timers();
      logic [31:0] r;
      bus_write(A_CTRL, 32'h0001_0006);
      check("R3 an timer off", 32'(an_tmr_off_o), 1);
      check("R3 lf timer off", 32'(lf_tmr_off_o), 1);
      bus_read(A_CTRL, r); check("R3 readback", r, 32'h0001_0006);
      bus_write(A_CTRL, 32'h0001_0004);
      check("R3 an timer on", 32'(an_tmr_off_o), 0);
      check("R3 lf still off", 32'(lf_tmr_off_o), 1);
   endtask

   task automatic t_force();
      logic [31:0] r;
      bus_write(A_CTRL, 32'h0001_00A0);
      check("R2 force not applied", 32'(force_mode_o), 0);
      check("R1 no pulse without bit0", 32'(seq_rst_o), 0);
      bus_read(A_CTRL, r); check("R2 force readback", r, 32'h0001_00A0);
      bus_write(A_CTRL, 32'h0001_00A1);
      check("R1 reset pulse high", 32'(seq_rst_o), 1);
      check("R2 force applied", 32'(force_mode_o), 32'hA);
      @(negedge clk);
      check("R1 reset pulse low", 32'(seq_rst_o), 0);
      bus_read(A_CTRL, r); check("R1 bit0 reads 0", r, 32'h0001_00A0);
   endtask

   task automatic t_ltresp();
      bus_write(A_CTRL, 32'h0001_10A0);
      check("R4 data mode on failure", 32'(lt_fail_data_o), 1);
      bus_write(A_CTRL, 32'h0001_00A0);
      check("R4 restart on failure", 32'(lt_fail_data_o), 0);
   endtask

   task automatic t_fec();
      logic [31:0] r;
      bus_write(A_CTRL, 32'h0000_00A0);
      check("R5 fec disabled", 32'(fec_en_o), 0);
      bus_write(A_CTRL, 32'h0001_00A0);
      check("R5 fec enabled", 32'(fec_en_o), 1);
      bus_write(A_CTRL, 32'h0005_00A0);
      check("R5 request held back", 32'(fec_req_o), 0);
      bus_read(A_CTRL, r); check("R6 pending set", r, 32'h000D_00A0);
      bus_write(A_CTRL, 32'h0005_00A1);
      check("R5 request applied", 32'(fec_req_o), 1);
      bus_read(A_CTRL, r); check("R6 pending cleared", r, 32'h0005_00A0);
   endtask

   task automatic t_status();
      logic [31:0] r;
      link_rdy_i = 1'b1;
      bus_read(A_STAT, r); check("R7 link ready", r, 32'h1);
      @(negedge clk); an_tmo_evt_i = 1'b1; lt_tmo_evt_i = 1'b1;
      @(negedge clk); an_tmo_evt_i = 1'b0; lt_tmo_evt_i = 1'b0;
      repeat (3) @(negedge clk);
      bus_read(A_STAT, r); check("R7 timeouts sticky", r, 32'h7);
      @(negedge clk); an_restart_i = 1'b1;
      @(negedge clk); an_restart_i = 1'b0;
      bus_read(A_STAT, r); check("R7 an timeout cleared by restart", r, 32'h5);
      bus_write(A_CTRL, 32'h0005_00A1);
      bus_read(A_STAT, r); check("R7 lt timeout cleared by reset", r, 32'h1);
      link_rdy_i = 1'b0;
      bus_read(A_STAT, r); check("R7 link down", r, 32'h0);
   endtask

   task automatic t_eins();
      logic [31:0] r;
      bus_write(A_EINS, 32'h0000_0800);
      check("R8 error pulse high", 32'(fec_err_ins_o), 1);
      @(negedge clk);
      check("R8 error pulse low", 32'(fec_err_ins_o), 0);
      bus_write(A_EINS, 32'hFFFF_F7FF);
      check("R8 other bits no pulse", 32'(fec_err_ins_o), 0);
      bus_read(A_EINS, r); check("R8 reads 0", r, 0);
   endtask

   task automatic t_reserved();
      logic [31:0] r;
      bus_write(A_CTRL, 32'hFFFF_FFFF);
      bus_read(A_CTRL, r); check("R9 reserved ctrl bits", r, 32'h0005_10F6);
      check("R2 force all ones", 32'(force_mode_o), 32'hF);
      bus_write(A_STAT, 32'hFFFF_FFFF);
      bus_read(A_STAT, r); check("R9 status unwritable", r, 0);
      bus_read(A_CTRL, r); check("R9 ctrl untouched by status write", r, 32'h0005_10F6);
      bus_read(A_NONE, r); check("R9 unmapped reads 0", r, 0);
   endtask

   task automatic t_latency();
      @(negedge clk);
      bus_addr = A_CTRL;
      @(negedge clk);
      bus_addr = A_NONE;
      check("R10 data one cycle after address", bus_rdata, 32'h0005_10F6);
      @(negedge clk);
      check("R10 follows new address", bus_rdata, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_timers();
      t_force();
      t_ltresp();
      t_fec();
      t_status();
      t_eins();
      t_reserved();
      t_latency();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule